// File: doc/BRIEF.md
# Quad-Lane Redundancy Routing Switch

This block is a clocked digital model of a three-port, four-lane protection switch. Ports A and B each carry a working copy of a serial link. Port C is the shared side, for example a line interface or a fabric connection. Toward port C, every lane picks port A or port B through its own select bit, so single lanes can be moved to the spare path. From port C, traffic goes either to the selected port only (unicast, giving 1:1 protection with the other output idle) or to both ports at once (bicast, giving 1+1 protection or a tap for test equipment).

Each port can be looped back on itself for link diagnostics. Loopback affects only that port's output. Port C has two pin groups whose transmit and receive roles can be exchanged, so the block can face a partner device whose pinout is mirrored. The receive-equalization and transmit-emphasis settings of each port are registered and passed through unchanged for the analog drivers outside this block.

All controls are captured in a configuration register. Lane data passes through one output register, and every lane has the same latency.

Top module: `lane_redund_switch`

## Requirements
- R1: While reset is asserted, every data output, idle flag, pin-group enable, `eq_o` and `pe_o` reads zero, whatever the inputs are.
- R2: With port C loopback off, lane i of the port C transmit data carries lane i of port A when `sel_i[i]`=0 and lane i of port B when `sel_i[i]`=1.
- R3: In unicast mode (`bicast_i`=0), with loopback off on ports A and B, lane i received on port C goes to port A when `sel_i[i]`=0 and to port B when `sel_i[i]`=1. The other port's lane i is idle, so ports A and B are never both idle on the same lane.
- R4: In bicast mode (`bicast_i`=1), with loopback off on ports A and B, lane i received on port C goes to both port A and port B whatever `sel_i[i]` is, and neither idle flag is set.
- R5: An idle lane of port A or port B outputs all zeros and raises its bit in `a_idle_o` or `b_idle_o`. A lane that carries data has its flag low.
- R6: When a port's loopback enable is set (`lpbk_a_i`, `lpbk_b_i`, `lpbk_c_i`), every lane that the port transmits is its own received lane, and the flag is low. This overrides `sel_i` and `bicast_i` for that port.
- R7: Loopback on one port leaves the routing of the other two ports unchanged.
- R8: With `c_rev_i`=0, port C receives on `c_grp0_i` and transmits on `c_grp1_o`: `c_grp1_oe_o`=1, `c_grp0_oe_o`=0, and `c_grp0_o` is zero. With `c_rev_i`=1 the two groups swap all of these roles. Out of reset, exactly one enable is high.
- R9: Lane data reaches the outputs one clock edge after it is presented, with the same latency on every lane. A change on `sel_i`, `bicast_i`, a loopback enable or `c_rev_i` first affects the routed outputs two edges after it is presented.
- R10: `eq_i` (bit 0 port A, bit 1 port B, bit 2 port C) and `pe_i` (bits [1:0] port A, [3:2] port B, [5:4] port C) appear on `eq_o` and `pe_o` one edge after they are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_rx_i | input | LANES*DW | Port A received lanes; lane i occupies bits [i*DW +: DW] |
| b_rx_i | input | LANES*DW | Port B received lanes |
| c_grp0_i | input | LANES*DW | Port C pin group 0; this is the receive group when not reversed |
| c_grp1_i | input | LANES*DW | Port C pin group 1; this is the receive group when reversed |
| sel_i | input | LANES | Per-lane select: 0 = port A, 1 = port B |
| bicast_i | input | 1 | 1 = send port C traffic to both A and B |
| lpbk_a_i | input | 1 | Loopback enable for port A |
| lpbk_b_i | input | 1 | Loopback enable for port B |
| lpbk_c_i | input | 1 | Loopback enable for port C |
| c_rev_i | input | 1 | Swap the roles of port C's pin groups |
| eq_i | input | 3 | Per-port equalization setting |
| pe_i | input | 6 | Per-port 2-bit emphasis level |
| a_tx_o | output | LANES*DW | Port A transmitted lanes |
| b_tx_o | output | LANES*DW | Port B transmitted lanes |
| c_grp0_o | output | LANES*DW | Port C pin group 0 drive data |
| c_grp1_o | output | LANES*DW | Port C pin group 1 drive data |
| a_idle_o | output | LANES | Per-lane idle flags of port A |
| b_idle_o | output | LANES | Per-lane idle flags of port B |
| c_grp0_oe_o | output | 1 | Drive enable for pin group 0 |
| c_grp1_oe_o | output | 1 | Drive enable for pin group 1 |
| eq_o | output | 3 | Registered equalization settings |
| pe_o | output | 6 | Registered emphasis settings |

## Verification
The bench builds the block with the default four lanes of eight-bit words. With that size, all 32 combinations of bicast, the three loopback enables and the port C swap can be crossed with all 16 per-lane select patterns. Every lane of every output is compared against a model of the routing table. Each lane word encodes its port, its lane number and a running seed, and is never zero. This exposes a misrouted, swapped or wrongly idled lane at once. Separate sequences check reset values, the one-edge data latency and the two-edge latency of a control change.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    localparam int NPORT = 3;
    localparam int EQ_W  = 1;
    localparam int PE_W  = 2;
    localparam int EQ_BITS = NPORT * EQ_W;
    localparam int PE_BITS = NPORT * PE_W;

    typedef struct packed {
        logic bicast;
        logic lb_a;
        logic lb_b;
        logic lb_c;
        logic rev;
    } lrs_mode_t;

endpackage

// File: rtl/lrs_cfg_reg.sv
module lrs_cfg_reg
    import lrs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LANES-1:0]     sel_i,
    input  lrs_mode_t            mode_i,
    input  logic [EQ_BITS-1:0]   eq_i,
    input  logic [PE_BITS-1:0]   pe_i,
    output logic [LANES-1:0]     sel_q_o,
    output lrs_mode_t            mode_q_o,
    output logic [EQ_BITS-1:0]   eq_q_o,
    output logic [PE_BITS-1:0]   pe_q_o
);

    typedef struct packed {
        logic [LANES-1:0]   sel;
        lrs_mode_t          mode;
        logic [EQ_BITS-1:0] eq;
        logic [PE_BITS-1:0] pe;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d      = cfg_q;
        cfg_d.sel  = sel_i;
        cfg_d.mode = mode_i;
        cfg_d.eq   = eq_i;
        cfg_d.pe   = pe_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign sel_q_o  = cfg_q.sel;
    assign mode_q_o = cfg_q.mode;
    assign eq_q_o   = cfg_q.eq;
    assign pe_q_o   = cfg_q.pe;

endmodule

// File: rtl/lrs_lane_xbar.sv
module lrs_lane_xbar #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_rx_i,
    input  logic [DW-1:0] b_rx_i,
    input  logic [DW-1:0] c_rx_i,
    input  logic          sel_i,
    input  logic          bicast_i,
    input  logic          lb_a_i,
    input  logic          lb_b_i,
    input  logic          lb_c_i,
    output logic [DW-1:0] a_tx_o,
    output logic [DW-1:0] b_tx_o,
    output logic [DW-1:0] c_tx_o,
    output logic          a_idle_o,
    output logic          b_idle_o
);

    logic a_gets_c;
    logic b_gets_c;

    always_comb begin
        a_gets_c = bicast_i | ~sel_i;
        b_gets_c = bicast_i |  sel_i;

        if (lb_c_i) begin
            c_tx_o = c_rx_i;
        end else if (sel_i) begin
            c_tx_o = b_rx_i;
        end else begin
            c_tx_o = a_rx_i;
        end

        if (lb_a_i) begin
            a_tx_o   = a_rx_i;
            a_idle_o = 1'b0;
        end else if (a_gets_c) begin
            a_tx_o   = c_rx_i;
            a_idle_o = 1'b0;
        end else begin
            a_tx_o   = '0;
            a_idle_o = 1'b1;
        end

        if (lb_b_i) begin
            b_tx_o   = b_rx_i;
            b_idle_o = 1'b0;
        end else if (b_gets_c) begin
            b_tx_o   = c_rx_i;
            b_idle_o = 1'b0;
        end else begin
            b_tx_o   = '0;
            b_idle_o = 1'b1;
        end
    end

endmodule

// File: rtl/lrs_c_pins.sv
module lrs_c_pins #(
    parameter int W = 32
) (
    input  logic         rev_i,
    input  logic [W-1:0] grp0_i,
    input  logic [W-1:0] grp1_i,
    input  logic [W-1:0] c_tx_i,
    output logic [W-1:0] c_rx_o,
    output logic [W-1:0] grp0_o,
    output logic [W-1:0] grp1_o,
    output logic         grp0_oe_o,
    output logic         grp1_oe_o
);

    always_comb begin
        if (rev_i) begin
            c_rx_o    = grp1_i;
            grp0_o    = c_tx_i;
            grp1_o    = '0;
            grp0_oe_o = 1'b1;
            grp1_oe_o = 1'b0;
        end else begin
            c_rx_o    = grp0_i;
            grp0_o    = '0;
            grp1_o    = c_tx_i;
            grp0_oe_o = 1'b0;
            grp1_oe_o = 1'b1;
        end
    end

endmodule

// File: rtl/lane_redund_switch.sv
module lane_redund_switch
    import lrs_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES*DW-1:0]      a_rx_i,
    input  logic [LANES*DW-1:0]      b_rx_i,
    input  logic [LANES*DW-1:0]      c_grp0_i,
    input  logic [LANES*DW-1:0]      c_grp1_i,
    input  logic [LANES-1:0]         sel_i,
    input  logic                     bicast_i,
    input  logic                     lpbk_a_i,
    input  logic                     lpbk_b_i,
    input  logic                     lpbk_c_i,
    input  logic                     c_rev_i,
    input  logic [2:0]               eq_i,
    input  logic [5:0]               pe_i,
    output logic [LANES*DW-1:0]      a_tx_o,
    output logic [LANES*DW-1:0]      b_tx_o,
    output logic [LANES*DW-1:0]      c_grp0_o,
    output logic [LANES*DW-1:0]      c_grp1_o,
    output logic [LANES-1:0]         a_idle_o,
    output logic [LANES-1:0]         b_idle_o,
    output logic                     c_grp0_oe_o,
    output logic                     c_grp1_oe_o,
    output logic [2:0]               eq_o,
    output logic [5:0]               pe_o
);

    localparam int W = LANES * DW;

    typedef struct packed {
        logic [W-1:0]     a;
        logic [W-1:0]     b;
        logic [W-1:0]     g0;
        logic [W-1:0]     g1;
        logic [LANES-1:0] a_idle;
        logic [LANES-1:0] b_idle;
        logic             oe0;
        logic             oe1;
    } out_t;

    lrs_mode_t            mode_in;
    lrs_mode_t            mode_q;
    logic [LANES-1:0]     sel_q;
    logic [EQ_BITS-1:0]   eq_q;
    logic [PE_BITS-1:0]   pe_q;

    logic [W-1:0]         c_rx_w;
    logic [W-1:0]         c_tx_w;
    logic [W-1:0]         a_tx_w;
    logic [W-1:0]         b_tx_w;
    logic [W-1:0]         g0_w;
    logic [W-1:0]         g1_w;
    logic [LANES-1:0]     a_idle_w;
    logic [LANES-1:0]     b_idle_w;
    logic                 oe0_w;
    logic                 oe1_w;

    out_t out_d, out_q;

    always_comb begin
        mode_in.bicast = bicast_i;
        mode_in.lb_a   = lpbk_a_i;
        mode_in.lb_b   = lpbk_b_i;
        mode_in.lb_c   = lpbk_c_i;
        mode_in.rev    = c_rev_i;
    end

    lrs_cfg_reg #(
        .LANES (LANES)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel_i),
        .mode_i   (mode_in),
        .eq_i     (eq_i),
        .pe_i     (pe_i),
        .sel_q_o  (sel_q),
        .mode_q_o (mode_q),
        .eq_q_o   (eq_q),
        .pe_q_o   (pe_q)
    );

    lrs_c_pins #(
        .W (W)
    ) cpins_i (
        .rev_i     (mode_q.rev),
        .grp0_i    (c_grp0_i),
        .grp1_i    (c_grp1_i),
        .c_tx_i    (c_tx_w),
        .c_rx_o    (c_rx_w),
        .grp0_o    (g0_w),
        .grp1_o    (g1_w),
        .grp0_oe_o (oe0_w),
        .grp1_oe_o (oe1_w)
    );

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        lrs_lane_xbar #(
            .DW (DW)
        ) xbar_i (
            .a_rx_i   (a_rx_i[ln*DW +: DW]),
            .b_rx_i   (b_rx_i[ln*DW +: DW]),
            .c_rx_i   (c_rx_w[ln*DW +: DW]),
            .sel_i    (sel_q[ln]),
            .bicast_i (mode_q.bicast),
            .lb_a_i   (mode_q.lb_a),
            .lb_b_i   (mode_q.lb_b),
            .lb_c_i   (mode_q.lb_c),
            .a_tx_o   (a_tx_w[ln*DW +: DW]),
            .b_tx_o   (b_tx_w[ln*DW +: DW]),
            .c_tx_o   (c_tx_w[ln*DW +: DW]),
            .a_idle_o (a_idle_w[ln]),
            .b_idle_o (b_idle_w[ln])
        );
    end

    always_comb begin
        out_d        = out_q;
        out_d.a      = a_tx_w;
        out_d.b      = b_tx_w;
        out_d.g0     = g0_w;
        out_d.g1     = g1_w;
        out_d.a_idle = a_idle_w;
        out_d.b_idle = b_idle_w;
        out_d.oe0    = oe0_w;
        out_d.oe1    = oe1_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign a_tx_o      = out_q.a;
    assign b_tx_o      = out_q.b;
    assign c_grp0_o    = out_q.g0;
    assign c_grp1_o    = out_q.g1;
    assign a_idle_o    = out_q.a_idle;
    assign b_idle_o    = out_q.b_idle;
    assign c_grp0_oe_o = out_q.oe0;
    assign c_grp1_oe_o = out_q.oe1;
    assign eq_o        = eq_q;
    assign pe_o        = pe_q;

endmodule

// File: rtl/lrs_chk.sv
module lrs_chk #(
    parameter int LANES = 4,
    parameter int DW    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [LANES*DW-1:0] a_rx_i,
    input logic                bicast_i,
    input logic                lpbk_a_i,
    input logic                lpbk_b_i,
    input logic                c_rev_i,
    input logic [2:0]          eq_i,
    input logic [LANES*DW-1:0] a_tx_o,
    input logic [LANES*DW-1:0] b_tx_o,
    input logic [LANES-1:0]    a_idle_o,
    input logic [LANES-1:0]    b_idle_o,
    input logic                c_grp0_oe_o,
    input logic                c_grp1_oe_o,
    input logic [2:0]          eq_o
);

    logic [1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (seen != 2'd3) begin
            seen <= seen + 2'd1;
        end
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_idle
        AST_IDLE_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
            a_idle_o[ln] |-> (a_tx_o[ln*DW +: DW] == '0)); // R5
        AST_IDLE_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
            b_idle_o[ln] |-> (b_tx_o[ln*DW +: DW] == '0)); // R5
    end

    AST_IDLE_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) |-> ((a_idle_o & b_idle_o) == '0)); // R3

    AST_BICAST_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && $past(bicast_i, 2) && !$past(lpbk_a_i, 2) && !$past(lpbk_b_i, 2))
        |-> ((a_idle_o | b_idle_o) == '0)); // R4

    AST_LOOP_A: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && $past(lpbk_a_i, 2))
        |-> (a_tx_o == $past(a_rx_i) && a_idle_o == '0)); // R6

    AST_OE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) |-> ($countones({c_grp0_oe_o, c_grp1_oe_o}) == 1)); // R8

    AST_OE_REV: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) |-> (c_grp0_oe_o == $past(c_rev_i, 2))); // R8

    AST_EQ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd1) |-> (eq_o == $past(eq_i))); // R10

endmodule

bind lane_redund_switch lrs_chk #(.LANES(LANES), .DW(DW)) chk_i (.*);

// File: tb/lane_redund_switch_tb_top.sv
`timescale 1ns/1ps
module lane_redund_switch_tb_top;

    localparam int LANES = 4;
    localparam int DW    = 8;
    localparam int W     = LANES * DW;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [W-1:0]     a_rx, b_rx, g0_in, g1_in;
    logic [LANES-1:0] sel;
    logic             bicast, lb_a, lb_b, lb_c, rev;
    logic [2:0]       eq_in;
    logic [5:0]       pe_in;
    logic [W-1:0]     a_tx, b_tx, g0_out, g1_out;
    logic [LANES-1:0] a_idle, b_idle;
    logic             oe0, oe1;
    logic [2:0]       eq_out;
    logic [5:0]       pe_out;

    logic [W-1:0]     ex_a, ex_b, ex_g0, ex_g1;
    logic [LANES-1:0] ex_ai, ex_bi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lane_redund_switch #(.LANES(LANES), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_rx_i(a_rx), .b_rx_i(b_rx), .c_grp0_i(g0_in), .c_grp1_i(g1_in),
        .sel_i(sel), .bicast_i(bicast), .lpbk_a_i(lb_a), .lpbk_b_i(lb_b),
        .lpbk_c_i(lb_c), .c_rev_i(rev), .eq_i(eq_in), .pe_i(pe_in),
        .a_tx_o(a_tx), .b_tx_o(b_tx), .c_grp0_o(g0_out), .c_grp1_o(g1_out),
        .a_idle_o(a_idle), .b_idle_o(b_idle), .c_grp0_oe_o(oe0), .c_grp1_oe_o(oe1),
        .eq_o(eq_out), .pe_o(pe_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [3:0] seed);
        for (int l = 0; l < LANES; l++) begin
            a_rx[l*DW +: DW]  = {2'd1, l[1:0], seed};
            b_rx[l*DW +: DW]  = {2'd2, l[1:0], seed};
            g0_in[l*DW +: DW] = {2'd3, l[1:0], seed};
            g1_in[l*DW +: DW] = {2'd3, l[1:0], ~seed};
        end
    endtask

    // Reference of the routing table, computed lane by lane from the requirements
    task automatic model(input logic [LANES-1:0] s);
        logic [W-1:0] crx, ctx;
        crx = rev ? g1_in : g0_in;
        for (int l = 0; l < LANES; l++) begin
            logic [DW-1:0] cl;
            cl = crx[l*DW +: DW];
            ctx[l*DW +: DW] = lb_c ? cl : (s[l] ? b_rx[l*DW +: DW] : a_rx[l*DW +: DW]);
            if (lb_a) begin
                ex_a[l*DW +: DW] = a_rx[l*DW +: DW]; ex_ai[l] = 1'b0;
            end else if (bicast || !s[l]) begin
                ex_a[l*DW +: DW] = cl; ex_ai[l] = 1'b0;
            end else begin
                ex_a[l*DW +: DW] = '0; ex_ai[l] = 1'b1;
            end
            if (lb_b) begin
                ex_b[l*DW +: DW] = b_rx[l*DW +: DW]; ex_bi[l] = 1'b0;
            end else if (bicast || s[l]) begin
                ex_b[l*DW +: DW] = cl; ex_bi[l] = 1'b0;
            end else begin
                ex_b[l*DW +: DW] = '0; ex_bi[l] = 1'b1;
            end
        end
        ex_g0 = rev ? ctx : '0;
        ex_g1 = rev ? '0 : ctx;
    endtask

    task automatic check_all();
        string ta, tb, tc;
        ta = lb_a ? "R6" : (bicast ? "R4" : "R3");
        tb = lb_b ? "R6" : (bicast ? "R4" : "R3");
        tc = lb_c ? "R6" : "R2";
        if (lb_b || lb_c) ta = {ta, "/R7"};
        if (lb_a || lb_c) tb = {tb, "/R7"};
        if (lb_a || lb_b) tc = {tc, "/R7"};
        chk({ta, " port A data"}, a_tx, ex_a);
        chk({tb, " port B data"}, b_tx, ex_b);
        chk({tc, "/R8 group0 data"}, g0_out, ex_g0);
        chk({tc, "/R8 group1 data"}, g1_out, ex_g1);
        chk("R5 idle flags A", a_idle, ex_ai);
        chk("R5 idle flags B", b_idle, ex_bi);
        chk("R8 enables", {oe0, oe1}, {rev, !rev});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        sel = 4'b1010; bicast = 1'b1; lb_a = 1'b1; lb_b = 1'b0; lb_c = 1'b1; rev = 1'b1;
        eq_in = 3'b111; pe_in = 6'b111111;
        fill(4'h5);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: everything zero while reset is held
        chk("R1 reset data", {a_tx, b_tx}, '0);
        chk("R1 reset groups", {g0_out, g1_out}, '0);
        chk("R1 reset flags", {a_idle, b_idle, oe0, oe1}, '0);
        chk("R1 reset eq/pe", {eq_out, pe_out}, '0);
        rst_n = 1'b1;

        // Full sweep of mode bits against every select pattern
        for (int m = 0; m < 32; m++) begin
            for (int s = 0; s < 16; s++) begin
                @(negedge clk);
                {bicast, lb_a, lb_b, lb_c, rev} = m[4:0];
                sel = s[3:0];
                eq_in = m[2:0] ^ s[2:0];
                pe_in = {s[1:0], m[3:0]};
                fill(s[3:0] ^ m[3:0]);
                @(posedge clk);
                @(posedge clk);
                @(negedge clk);
                model(sel);
                check_all();
                chk("R10 eq passthrough", eq_out, eq_in);
                chk("R10 pe passthrough", pe_out, pe_in);
            end
        end

        // R9: data latency of one edge
        @(negedge clk);
        {bicast, lb_a, lb_b, lb_c, rev} = 5'b00000;
        sel = 4'b0101;
        fill(4'h1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        fill(4'h9);
        @(posedge clk);
        #5;
        model(sel);
        chk("R9 data one edge", g1_out, ex_g1);
        chk("R9 data one edge port A", a_tx, ex_a);

        // R9: control change needs two edges
        @(negedge clk);
        sel = 4'b1010;
        @(posedge clk);
        #5;
        model(4'b0101);
        chk("R9 control not yet applied", g1_out, ex_g1);
        chk("R9 control not yet applied idle", b_idle, ex_bi);
        @(posedge clk);
        #5;
        model(4'b1010);
        chk("R9 control applied", g1_out, ex_g1);
        chk("R9 control applied idle", b_idle, ex_bi);

        // R8: reversal takes effect together with data on the same edge
        @(negedge clk);
        rev = 1'b1;
        @(posedge clk);
        #5;
        chk("R8 reverse pending", {oe0, oe1}, 2'b01);
        @(posedge clk);
        #5;
        model(sel);
        chk("R8 reverse applied", {oe0, oe1, g0_out}, {2'b10, ex_g0});

        // R10: settings one edge after presentation
        @(negedge clk);
        eq_in = 3'b101;
        pe_in = 6'b100111;
        @(posedge clk);
        #5;
        chk("R10 eq one edge", eq_out, 3'b101);
        chk("R10 pe one edge", pe_out, 6'b100111);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule